// File: doc/BRIEF.md
# CAN Sleep and Wake-up Controller

This block decides when each of two CAN channels may drop into a low-power sleep state and records the events that bring them back. Software asks for sleep through a per-channel request bit. The block grants that request only once the channel has no interrupt waiting and its bus is quiet. A channel that is asleep leaves sleep when its raw receive line shows a falling edge.

Every falling edge on a receive line is also latched into a shared wake flag register. Software reads that register and clears its bits by writing ones. A per-channel enable turns a latched flag into a level wake-up interrupt. Clock gating, the protocol engine and the interrupt controller sit outside this block. It only produces the sleep state and the wake indications.

Top module: `can_sleep_wake`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), every sleep request, every sleep state, every wake flag and every wake interrupt reads 0.
- R2: A write of 1 to a channel's sleep request (sreq_wr with sreq_wdata 1) sets the bit only if that channel's reset_mode is 0 at that edge. With reset_mode 1 the write is ignored. A write of 0 clears the bit whatever reset_mode is.
- R3: A channel's asleep output rises at the clock edge after its sleep request reads 1, provided irq_pending and bus_active are both 0 at that edge. While either of them is 1, the channel stays awake.
- R4: A falling edge detected on a sleeping channel's receive line clears both its asleep output and its sleep request at the same edge. A falling edge on an awake channel leaves its sleep request unchanged.
- R5: Each receive line passes through a two-flop synchronizer. A 1-to-0 change on the line sets that channel's wake flag at the third rising clock edge after the change. A 0-to-1 change and a steady level set nothing.
- R6: A write to the wake flag register with a 1 in a flag's bit clears that flag. A 0 in that bit leaves the flag unchanged.
- R7: If a falling edge and a clearing write hit the same flag at the same edge, the flag ends up 1.
- R8: In the wake flag register, channel 0 sits in bit 1 and channel 1 in bit 2. Bit 0 and bits 31:3 always read 0, and writes to them have no effect.
- R9: wake_irq of a channel is 1 exactly when that channel's wake flag is 1 and its wake_ie input is 1.
- R10: Stimulus on one channel never changes the sleep request, the sleep state or the wake flag of the other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rxd | input | NCH | Raw receive data line per channel (asynchronous) |
| reset_mode | input | NCH | Channel is held in reset mode |
| irq_pending | input | NCH | Channel has a CAN interrupt pending |
| bus_active | input | NCH | Channel sees activity on its bus |
| sreq_wr | input | NCH | Write strobe for the sleep request bit |
| sreq_wdata | input | NCH | Value written to the sleep request bit |
| wake_ie | input | NCH | Wake-up interrupt enable per channel |
| wflag_wr | input | 1 | Write strobe for the wake flag register |
| wflag_wdata | input | REG_W | Write data for the wake flag register (ones clear) |
| wflag_rdata | output | REG_W | Wake flag register read value |
| sleep_req | output | NCH | Current sleep request bit per channel |
| asleep | output | NCH | Channel is in sleep |
| wake_irq | output | NCH | Wake-up interrupt per channel |

## Verification
The bench builds the block with its defaults: two channels, a 32-bit flag register and a two-stage synchronizer. Two channels are few enough to sweep every combination of reset_mode, irq_pending and bus_active on each channel. Each combination runs through a request, a possible sleep entry and a wake-up, while the untouched channel is watched for leakage. The flag register is swept over all eight values of its low three write bits, with the reserved bits written as ones, so every clear mask and the reserved-bit behaviour are covered. A directed case lines up a clearing write with the edge at which a falling edge is latched.

// File: rtl/can_sw_pkg.sv
// Package: shared constants and helpers for the CAN sleep/wake block.
// Assumes the flag register places channel flags contiguously from FLAG_LSB.
package can_sw_pkg;

    // Bit position of channel 0 in the wake flag register.
    localparam int FLAG_LSB = 1;

    // Default number of synchronizer stages on each receive line.
    localparam int SYNC_DEPTH = 2;

    // Mask of the implemented flag bits for a register of width w with n channels.
    function automatic logic [31:0] flag_mask(input int n);
        logic [31:0] m;
        m = '0;
        for (int i = 0; i < n; i++) begin
            m[FLAG_LSB + i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/can_rxd_fall_det.sv
// Module: synchronizes one raw receive line and flags a 1-to-0 transition.
// Assumes rxd_raw is asynchronous; the line idles high (recessive), so all
// flops reset to 1 and no edge is reported on leaving reset.
module can_rxd_fall_det #(
    parameter int STAGES = can_sw_pkg::SYNC_DEPTH
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd_raw,
    output logic fall
);

    localparam int TOP = STAGES - 1;

    logic [TOP:0] sync_q;
    logic         prev_q;

    // Shift the raw line through the synchronizer chain.
    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= 1'b1;
                else        sync_q <= rxd_raw;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[TOP-1:0], rxd_raw};
            end
        end
    endgenerate

    // Hold the previous synchronized sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= sync_q[TOP];
    end

    assign fall = prev_q & ~sync_q[TOP];

    // R5
    no_double_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/can_sleep_ctrl.sv
// Module: sleep request bit and sleep state of one channel.
// Assumes wake is a single-cycle synchronized falling-edge pulse.
module can_sleep_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic reset_mode,
    input  logic irq_pending,
    input  logic bus_active,
    input  logic req_wr,
    input  logic req_wdata,
    input  logic wake,
    output logic req,
    output logic asleep
);

    logic req_q;
    logic asleep_q;
    logic wake_sleeping;

    assign wake_sleeping = wake & asleep_q;

    // Sleep request bit: set only outside reset mode, cleared by a write or a wake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else if (wake_sleeping) begin
            req_q <= 1'b0;
        end else if (req_wr) begin
            if (!req_wdata)       req_q <= 1'b0;
            else if (!reset_mode) req_q <= 1'b1;
        end
    end

    // Sleep state: enter on request with a quiet channel, leave on wake or withdrawn request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            asleep_q <= 1'b0;
        end else if (wake_sleeping || !req_q) begin
            asleep_q <= 1'b0;
        end else if (!asleep_q && !irq_pending && !bus_active && !wake) begin
            asleep_q <= 1'b1;
        end
    end

    assign req    = req_q;
    assign asleep = asleep_q;

    // R2
    rm_blocks_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_wr && req_wdata && reset_mode && !req_q && !wake) |=> !req_q);

    // R3
    entry_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(asleep_q) |-> $past(req_q && !irq_pending && !bus_active));

    // R4
    wake_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep_q && wake) |=> (!asleep_q && !req_q));

endmodule

// File: rtl/can_wake_flags.sv
// Module: shared write-one-to-clear wake flag register for all channels.
// Assumes wake_evt is one pulse per edge; a set beats a clear in the same cycle.
module can_wake_flags #(
    parameter int NCH   = 2,
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   wake_evt,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output logic [NCH-1:0]   flags,
    output logic [REG_W-1:0] rdata
);

    localparam int LSB = can_sw_pkg::FLAG_LSB;

    logic [NCH-1:0] flag_q;
    logic [NCH-1:0] clr;

    assign clr = wr ? wdata[LSB +: NCH] : '0;

    // Update flags: clear the written ones, then merge new events on top.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~clr) | wake_evt;
    end

    // Place the flags in the read word; everything else reads zero.
    always_comb begin
        rdata = '0;
        rdata[LSB +: NCH] = flag_q;
    end

    assign flags = flag_q;

    // R5
    set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|wake_evt) |=> ((flag_q & $past(wake_evt)) == $past(wake_evt)));

    // R6
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> ((flag_q & $past(clr & ~wake_evt)) == '0));

    // R6
    w0_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag_q & $past(flag_q & ~clr)) == $past(flag_q & ~clr)));

endmodule

// File: rtl/can_sleep_wake.sv
// Module: top of the CAN sleep/wake controller. Per channel it instantiates a
// receive-line edge detector and a sleep controller, and it shares one wake
// flag register across channels. Assumes NCH + FLAG_LSB <= REG_W.
module can_sleep_wake #(
    parameter int NCH   = 2,
    parameter int REG_W = 32,
    parameter int SYNC  = can_sw_pkg::SYNC_DEPTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   rxd,
    input  logic [NCH-1:0]   reset_mode,
    input  logic [NCH-1:0]   irq_pending,
    input  logic [NCH-1:0]   bus_active,
    input  logic [NCH-1:0]   sreq_wr,
    input  logic [NCH-1:0]   sreq_wdata,
    input  logic [NCH-1:0]   wake_ie,
    input  logic             wflag_wr,
    input  logic [REG_W-1:0] wflag_wdata,
    output logic [REG_W-1:0] wflag_rdata,
    output logic [NCH-1:0]   sleep_req,
    output logic [NCH-1:0]   asleep,
    output logic [NCH-1:0]   wake_irq
);

    logic [NCH-1:0] fall;
    logic [NCH-1:0] flags;

    // Per-channel edge detector and sleep controller.
    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            can_rxd_fall_det #(.STAGES(SYNC)) u_det (
                .clk     (clk),
                .rst_n   (rst_n),
                .rxd_raw (rxd[c]),
                .fall    (fall[c])
            );

            can_sleep_ctrl u_slp (
                .clk         (clk),
                .rst_n       (rst_n),
                .reset_mode  (reset_mode[c]),
                .irq_pending (irq_pending[c]),
                .bus_active  (bus_active[c]),
                .req_wr      (sreq_wr[c]),
                .req_wdata   (sreq_wdata[c]),
                .wake        (fall[c]),
                .req         (sleep_req[c]),
                .asleep      (asleep[c])
            );
        end
    endgenerate

    can_wake_flags #(.NCH(NCH), .REG_W(REG_W)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .wake_evt (fall),
        .wr       (wflag_wr),
        .wdata    (wflag_wdata),
        .flags    (flags),
        .rdata    (wflag_rdata)
    );

    assign wake_irq = flags & wake_ie;

    // R1
    reset_clean_chk: assert property (@(posedge clk)
        !rst_n |=> (sleep_req == '0 && asleep == '0 && wflag_rdata == '0));

    // R3
    asleep_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((asleep & ~$past(sleep_req)) == '0));

endmodule

// File: tb/sim_can_sleep_wake.sv
module sim_can_sleep_wake;

    localparam int CLK_NS = 10;
    localparam int NCH    = 2;
    localparam int REG_W  = 32;
    localparam int WDOG   = 100000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NCH-1:0]   rxd = '1;
    logic [NCH-1:0]   reset_mode = '0;
    logic [NCH-1:0]   irq_pending = '0;
    logic [NCH-1:0]   bus_active = '0;
    logic [NCH-1:0]   sreq_wr = '0;
    logic [NCH-1:0]   sreq_wdata = '0;
    logic [NCH-1:0]   wake_ie = '0;
    logic             wflag_wr = 1'b0;
    logic [REG_W-1:0] wflag_wdata = '0;
    logic [REG_W-1:0] wflag_rdata;
    logic [NCH-1:0]   sleep_req;
    logic [NCH-1:0]   asleep;
    logic [NCH-1:0]   wake_irq;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    can_sleep_wake #(.NCH(NCH), .REG_W(REG_W)) u0 (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG && !done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected <%0d cycles", cyc, WDOG);
            report();
        end
    end

    // Produce a falling edge on channel ch and wait until the flag is latched.
    task automatic fall_on(input int ch);
        rxd[ch] = 1'b0;
        step(3);
    endtask

    // Return line high and let the synchronizer settle.
    task automatic rise_on(input int ch);
        rxd[ch] = 1'b1;
        step(3);
    endtask

    task automatic clear_flags(input logic [31:0] m);
        wflag_wr = 1'b1;
        wflag_wdata = m;
        step(1);
        wflag_wr = 1'b0;
        wflag_wdata = '0;
    endtask

    initial begin
        step(3);
        // R1 reset state
        chk("R1 sleep_req", 32'(sleep_req), 0);
        chk("R1 asleep", 32'(asleep), 0);
        chk("R1 flags", wflag_rdata, 0);
        chk("R1 wake_irq", 32'(wake_irq), 0);
        rst_n = 1'b1;
        step(2);
        chk("R1 after release", wflag_rdata, 0);

        // Sweep each channel over reset_mode / irq_pending / bus_active.
        for (int ch = 0; ch < NCH; ch++) begin
            for (int c = 0; c < 8; c++) begin
                automatic int  oth = 1 - ch;
                automatic bit  rm  = c[0];
                automatic bit  ip  = c[1];
                automatic bit  ba  = c[2];
                automatic bit  exp_req = !rm;
                automatic bit  exp_slp = !rm && !ip && !ba;
                automatic logic [31:0] fbit = 32'(1) << (ch + 1);
                reset_mode[ch] = rm;
                irq_pending[ch] = ip;
                bus_active[ch] = ba;
                wake_ie[ch] = c[0] ^ c[1];
                sreq_wr[ch] = 1'b1;
                sreq_wdata[ch] = 1'b1;
                step(1);
                sreq_wr[ch] = 1'b0;
                // R2 set gated by reset mode
                chk("R2 set gating", 32'(sleep_req[ch]), 32'(exp_req));
                step(1);
                // R3 entry condition
                chk("R3 entry", 32'(asleep[ch]), 32'(exp_slp));
                step(2);
                chk("R3 held", 32'(asleep[ch]), 32'(exp_slp));
                // R10 other channel untouched
                chk("R10 other req", 32'(sleep_req[oth]), 0);
                chk("R10 other asleep", 32'(asleep[oth]), 0);
                // Wake with a falling edge.
                rxd[ch] = 1'b0;
                step(2);
                // R5 not yet latched after two edges
                chk("R5 latency", wflag_rdata & fbit, 0);
                step(1);
                chk("R5 flag set", wflag_rdata, fbit);
                // R4 sleeping channel wakes and drops its request
                chk("R4 asleep", 32'(asleep[ch]), 0);
                chk("R4 req", 32'(sleep_req[ch]), 32'(exp_req && !exp_slp));
                // R9 interrupt gating
                chk("R9 irq", 32'(wake_irq), 32'(wake_ie[ch]) << ch);
                // R6 write zero keeps
                clear_flags(~fbit & 32'h6);
                chk("R6 write0 keeps", wflag_rdata & fbit, fbit);
                clear_flags(fbit);
                chk("R6 write1 clears", wflag_rdata, 0);
                chk("R9 irq cleared", 32'(wake_irq), 0);
                // R5 rising edge sets nothing
                rise_on(ch);
                chk("R5 rise no set", wflag_rdata, 0);
                // R2 write zero clears under reset mode too
                reset_mode[ch] = 1'b1;
                sreq_wr[ch] = 1'b1;
                sreq_wdata[ch] = 1'b0;
                step(1);
                sreq_wr[ch] = 1'b0;
                chk("R2 clear", 32'(sleep_req[ch]), 0);
                reset_mode[ch] = 1'b0;
                irq_pending[ch] = 1'b0;
                bus_active[ch] = 1'b0;
                wake_ie[ch] = 1'b0;
                step(1);
                chk("R3 no req no sleep", 32'(asleep[ch]), 0);
            end
        end

        // R8 and R6 sweep of the clear mask with reserved bits set.
        for (int w = 0; w < 8; w++) begin
            automatic logic [31:0] wd  = 32'hFFFF_FFF8 | 32'(w);
            automatic logic [31:0] exp = 32'h6 & ~32'(w);
            rxd = '0;
            step(3);
            chk("R8 both set", wflag_rdata, 32'h6);
            clear_flags(wd);
            chk("R8 mask clear", wflag_rdata, exp);
            chk("R8 reserved zero", wflag_rdata & 32'hFFFF_FFF9, 0);
            rxd = '1;
            step(3);
            clear_flags(32'hFFFF_FFFF);
            chk("R6 all cleared", wflag_rdata, 0);
        end

        // R7 set wins over a same-edge clear (fall pulse visible after 2 edges).
        rxd[1] = 1'b0;
        step(2);
        clear_flags(32'h4);
        chk("R7 set wins", wflag_rdata, 32'h4);
        clear_flags(32'h4);
        chk("R7 later clear", wflag_rdata, 0);
        rise_on(1);

        // R4 awake channel with a falling edge keeps its request.
        irq_pending[0] = 1'b1;
        sreq_wr[0] = 1'b1;
        sreq_wdata[0] = 1'b1;
        step(1);
        sreq_wr[0] = 1'b0;
        fall_on(0);
        chk("R4 awake keeps req", 32'(sleep_req[0]), 1);
        chk("R4 stays awake", 32'(asleep[0]), 0);
        // R3 entry once the interrupt goes away
        irq_pending[0] = 1'b0;
        step(1);
        chk("R3 late entry", 32'(asleep[0]), 1);
        chk("R10 ch1 awake", 32'(asleep[1]), 0);

        // R1 reset in the middle of activity
        rst_n = 1'b0;
        step(1);
        chk("R1 mid reset req", 32'(sleep_req), 0);
        chk("R1 mid reset asleep", 32'(asleep), 0);
        chk("R1 mid reset flags", wflag_rdata, 0);

        done = 1'b1;
        report();
    end

endmodule